// File: doc/BRIEF.md
# Warp Scoreboard Issue Scheduler

This block picks, each clock cycle, at most one instruction to issue from several warps running on one SIMT cluster. Every warp shows the scheduler a small lookahead window of decoded instructions. Each entry has two source register indices, one destination register index and a unit type. A scoreboard holds one pending bit for each (warp, register) pair. The bit is set when an instruction that writes the register issues, and it is cleared when that result comes back. Results return a fixed pipeline latency after issue. Because the whole window is examined, an independent younger instruction can leave ahead of an older one that is still waiting for its operands. Ordering hazards inside the window are still respected.

The instruction goes to one of four execution ports: two vector ALUs, a special-function unit and a load/store unit. A port stays occupied for a fixed number of cycles after it accepts an instruction. A warp may not issue in two consecutive cycles. Among the warps that can issue, the choice rotates, starting just after the warp that issued most recently. The block produces the writeback event itself through an internal delay line and shows it on the wb_* outputs. The upstream window logic uses iss_warp and iss_slot to remove the issued entry before the next clock edge.

Top module: `warp_sb_sched`

## Requirements
- R1: After reset no registers are pending, no port is occupied, and no writeback is reported. When every warp can issue, the first grant goes to warp 0.
- R2: A window entry whose source or destination register is pending for its warp does not issue. A register whose writeback is reported in the current cycle counts as free in that cycle.
- R3: An instruction issued in cycle t sets the pending bit of its destination. In cycle t+LAT (LAT defaults to 18), wb_valid is 1 with that warp and register, and a reader of that register can issue in that same cycle.
- R4: Entry j of a window is blocked if any valid older entry k<j reads or writes its destination register, or writes one of its sources. Among a warp's unblocked entries, the lowest index is chosen, even when an older entry is stalled.
- R5: A warp that issued in cycle t does not issue in cycle t+1.
- R6: Among warps that have an issuable entry, the grant goes to the first one in the cyclic order that starts just after the most recently granted warp.
- R7: Type code 0 (ALU) goes to port 0 if that port is free, otherwise to port 1. Type code 1 (special function) goes to port 2. Type codes 2 and 3 (load/store) go to port 3. An entry whose ports are all occupied does not issue.
- R8: A port that accepts an instruction in cycle t is occupied until cycle t+OCC. OCC is ALU_OCC (default 2) for ports 0 and 1, SFU_OCC (default 4) for port 2, and 1 for port 3.
- R9: At most one instruction issues per cycle. iss_src0, iss_src1 and iss_dst carry the register fields of the window entry named by iss_warp and iss_slot, and that entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_valid | input | NW*WIN | Window entry valid, per warp and slot (slot 0 is oldest) |
| win_src0 | input | NW*WIN*RW | First source register index per entry |
| win_src1 | input | NW*WIN*RW | Second source register index per entry |
| win_dst | input | NW*WIN*RW | Destination register index per entry |
| win_type | input | NW*WIN*2 | Unit type per entry: 0 ALU, 1 SFU, 2/3 load/store |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_warp | output | WW | Warp of the issued instruction |
| iss_slot | output | SW | Window slot of the issued instruction |
| iss_port | output | 2 | Target port: 0/1 ALU, 2 SFU, 3 load/store |
| iss_src0 | output | RW | First source of the issued instruction |
| iss_src1 | output | RW | Second source of the issued instruction |
| iss_dst | output | RW | Destination of the issued instruction |
| wb_valid | output | 1 | Writeback event this cycle |
| wb_warp | output | WW | Warp of the writeback |
| wb_reg | output | RW | Register of the writeback |

## Verification
Some properties are checked on every cycle. An issued entry never has a busy operand. Its destination is marked pending on the next cycle. A writeback only names a pending register. A warp never issues twice in a row. The port matches the unit type, and a multi-cycle port is not reused on the next cycle. Other behaviour can only be shown by the bench scenarios, which compare every grant against a timing model of ready times. These are the exact LAT-cycle spacing of a dependent pair, a younger entry overtaking a stalled one, a write held behind an older reader, the rotation order, the ALU spill to port 1, and the spacing on the special-function port.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    typedef enum logic [1:0] {
        UNIT_ALU     = 2'd0,
        UNIT_SFU     = 2'd1,
        UNIT_LSU     = 2'd2,
        UNIT_LSU_ALT = 2'd3
    } unit_e;

    localparam int NPORT = 4;
    localparam logic [1:0] PORT_ALU0 = 2'd0;
    localparam logic [1:0] PORT_ALU1 = 2'd1;
    localparam logic [1:0] PORT_SFU  = 2'd2;
    localparam logic [1:0] PORT_LSU  = 2'd3;
endpackage

// File: rtl/sbs_slot_pick.sv
module sbs_slot_pick
    import sbs_pkg::*;
#(
    parameter int WIN  = 4,
    parameter int NREG = 16,
    localparam int SW  = $clog2(WIN),
    localparam int RW  = $clog2(NREG)
) (
    input  logic [WIN-1:0]          valid,
    input  logic [WIN-1:0][RW-1:0]  src0,
    input  logic [WIN-1:0][RW-1:0]  src1,
    input  logic [WIN-1:0][RW-1:0]  dst,
    input  logic [WIN-1:0][1:0]     utype,
    input  logic [NREG-1:0]         pend,
    input  logic [NPORT-1:0]        port_free,
    output logic                    found,
    output logic [SW-1:0]           slot
);
    logic [WIN-1:0] elig;

    for (genvar j = 0; j < WIN; j++) begin : g_slot
        logic unit_ok;
        logic order_ok;

        always_comb begin
            case (unit_e'(utype[j]))
                UNIT_ALU: unit_ok = port_free[PORT_ALU0] | port_free[PORT_ALU1];
                UNIT_SFU: unit_ok = port_free[PORT_SFU];
                default:  unit_ok = port_free[PORT_LSU];
            endcase
        end

        always_comb begin
            order_ok = 1'b1;
            for (int k = 0; k < j; k++) begin
                if (valid[k] &&
                    ((dst[j] == src0[k]) || (dst[j] == src1[k]) ||
                     (dst[j] == dst[k])  ||
                     (src0[j] == dst[k]) || (src1[j] == dst[k]))) begin
                    order_ok = 1'b0;
                end
            end
        end

        assign elig[j] = valid[j] & unit_ok & order_ok &
                         ~pend[src0[j]] & ~pend[src1[j]] & ~pend[dst[j]];
    end

    always_comb begin
        found = |elig;
        slot  = '0;
        for (int j = WIN - 1; j >= 0; j--) begin
            if (elig[j]) begin
                slot = SW'(j);
            end
        end
    end
endmodule

// File: rtl/sbs_rr_pick.sv
module sbs_rr_pick #(
    parameter int NW  = 4,
    localparam int WW = $clog2(NW)
) (
    input  logic [NW-1:0] req,
    input  logic [WW-1:0] last,
    output logic          gnt_v,
    output logic [WW-1:0] gnt_w
);
    always_comb begin
        gnt_v = 1'b0;
        gnt_w = '0;
        for (int i = NW; i >= 1; i--) begin
            int c;
            c = (int'(last) + i) % NW;
            if (req[c]) begin
                gnt_v = 1'b1;
                gnt_w = WW'(c);
            end
        end
    end
endmodule

// File: rtl/sbs_wb_line.sv
module sbs_wb_line #(
    parameter int LAT = 18,
    parameter int WW  = 2,
    parameter int RW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [WW-1:0] push_warp,
    input  logic [RW-1:0] push_reg,
    output logic          out_v,
    output logic [WW-1:0] out_warp,
    output logic [RW-1:0] out_reg
);
    typedef struct packed {
        logic [LAT-1:0]         v;
        logic [LAT-1:0][WW-1:0] w;
        logic [LAT-1:0][RW-1:0] r;
    } line_t;

    line_t ln_d, ln_q;

    always_comb begin
        ln_d   = ln_q;
        ln_d.v = {ln_q.v[LAT-2:0], push};
        ln_d.w = {ln_q.w[LAT-2:0], push_warp};
        ln_d.r = {ln_q.r[LAT-2:0], push_reg};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign out_v    = ln_q.v[LAT-1];
    assign out_warp = ln_q.w[LAT-1];
    assign out_reg  = ln_q.r[LAT-1];
endmodule

// File: rtl/warp_sb_sched.sv
module warp_sb_sched
    import sbs_pkg::*;
#(
    parameter int NW      = 4,
    parameter int WIN     = 4,
    parameter int NREG    = 16,
    parameter int LAT     = 18,
    parameter int ALU_OCC = 2,
    parameter int SFU_OCC = 4,
    localparam int WW     = $clog2(NW),
    localparam int SW     = $clog2(WIN),
    localparam int RW     = $clog2(NREG)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NW-1:0][WIN-1:0]          win_valid,
    input  logic [NW-1:0][WIN-1:0][RW-1:0]  win_src0,
    input  logic [NW-1:0][WIN-1:0][RW-1:0]  win_src1,
    input  logic [NW-1:0][WIN-1:0][RW-1:0]  win_dst,
    input  logic [NW-1:0][WIN-1:0][1:0]     win_type,
    output logic                            iss_valid,
    output logic [WW-1:0]                   iss_warp,
    output logic [SW-1:0]                   iss_slot,
    output logic [1:0]                      iss_port,
    output logic [RW-1:0]                   iss_src0,
    output logic [RW-1:0]                   iss_src1,
    output logic [RW-1:0]                   iss_dst,
    output logic                            wb_valid,
    output logic [WW-1:0]                   wb_warp,
    output logic [RW-1:0]                   wb_reg
);
    localparam int MAXOCC = (ALU_OCC > SFU_OCC) ? ALU_OCC : SFU_OCC;
    localparam int HW     = $clog2(MAXOCC + 1);

    typedef struct packed {
        logic [NW-1:0][NREG-1:0]  pend;
        logic [WW-1:0]            rr;
        logic                     prev_v;
        logic [WW-1:0]            prev_w;
        logic [NPORT-1:0][HW-1:0] hold;
    } state_t;

    localparam state_t ST_RST = '{
        pend:   '0,
        rr:     WW'(NW - 1),
        prev_v: 1'b0,
        prev_w: '0,
        hold:   '0
    };

    function automatic logic [HW-1:0] hold_init(input logic [1:0] p);
        case (p)
            PORT_ALU0, PORT_ALU1: hold_init = HW'(ALU_OCC - 1);
            PORT_SFU:             hold_init = HW'(SFU_OCC - 1);
            default:              hold_init = '0;
        endcase
    endfunction

    state_t st_d, st_q;

    logic [NW-1:0][NREG-1:0] pend_eff;
    logic [NPORT-1:0]        port_free;
    logic [NW-1:0]           w_found;
    logic [NW-1:0]           w_req;
    logic [NW-1:0][SW-1:0]   w_slot;
    logic                    gnt_v;
    logic [WW-1:0]           gnt_w;
    logic [1:0]              iss_type;

    // Writeback arriving this cycle frees its register at once.
    always_comb begin
        pend_eff = st_q.pend;
        if (wb_valid) begin
            pend_eff[wb_warp][wb_reg] = 1'b0;
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign port_free[p] = (st_q.hold[p] == '0);
    end

    for (genvar g = 0; g < NW; g++) begin : g_warp
        sbs_slot_pick #(
            .WIN  (WIN),
            .NREG (NREG)
        ) u_pick (
            .valid     (win_valid[g]),
            .src0      (win_src0[g]),
            .src1      (win_src1[g]),
            .dst       (win_dst[g]),
            .utype     (win_type[g]),
            .pend      (pend_eff[g]),
            .port_free (port_free),
            .found     (w_found[g]),
            .slot      (w_slot[g])
        );
        assign w_req[g] = w_found[g] & ~(st_q.prev_v & (st_q.prev_w == WW'(g)));
    end

    sbs_rr_pick #(
        .NW (NW)
    ) u_rr (
        .req   (w_req),
        .last  (st_q.rr),
        .gnt_v (gnt_v),
        .gnt_w (gnt_w)
    );

    assign iss_valid = gnt_v;
    assign iss_warp  = gnt_w;
    assign iss_slot  = w_slot[gnt_w];
    assign iss_src0  = win_src0[gnt_w][w_slot[gnt_w]];
    assign iss_src1  = win_src1[gnt_w][w_slot[gnt_w]];
    assign iss_dst   = win_dst[gnt_w][w_slot[gnt_w]];
    assign iss_type  = win_type[gnt_w][w_slot[gnt_w]];

    always_comb begin
        case (unit_e'(iss_type))
            UNIT_ALU: iss_port = port_free[PORT_ALU0] ? PORT_ALU0 : PORT_ALU1;
            UNIT_SFU: iss_port = PORT_SFU;
            default:  iss_port = PORT_LSU;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.pend = pend_eff;
        for (int p = 0; p < NPORT; p++) begin
            if (st_q.hold[p] != '0) begin
                st_d.hold[p] = st_q.hold[p] - 1'b1;
            end
        end
        if (gnt_v) begin
            st_d.pend[gnt_w][iss_dst] = 1'b1;
            st_d.hold[iss_port]       = hold_init(iss_port);
            st_d.rr                   = gnt_w;
        end
        st_d.prev_v = gnt_v;
        st_d.prev_w = gnt_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    sbs_wb_line #(
        .LAT (LAT),
        .WW  (WW),
        .RW  (RW)
    ) u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (gnt_v),
        .push_warp (gnt_w),
        .push_reg  (iss_dst),
        .out_v     (wb_valid),
        .out_warp  (wb_warp),
        .out_reg   (wb_reg)
    );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int NW      = 4,
    parameter int WIN     = 4,
    parameter int NREG    = 16,
    parameter int ALU_OCC = 2,
    parameter int SFU_OCC = 4,
    localparam int WW     = $clog2(NW),
    localparam int SW     = $clog2(WIN),
    localparam int RW     = $clog2(NREG)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NW-1:0][WIN-1:0]      win_valid,
    input logic [NW-1:0][WIN-1:0][1:0] win_type,
    input logic [NW-1:0][NREG-1:0]     pend,
    input logic                        iss_valid,
    input logic [WW-1:0]               iss_warp,
    input logic [SW-1:0]               iss_slot,
    input logic [1:0]                  iss_port,
    input logic [RW-1:0]               iss_src0,
    input logic [RW-1:0]               iss_src1,
    input logic [RW-1:0]               iss_dst,
    input logic                        wb_valid,
    input logic [WW-1:0]               wb_warp,
    input logic [RW-1:0]               wb_reg
);
    function automatic logic busy(input logic [RW-1:0] r);
        busy = pend[iss_warp][r] &&
               !(wb_valid && (wb_warp == iss_warp) && (wb_reg == r));
    endfunction

    logic       opnd_busy;
    logic [1:0] sel_type;

    always_comb begin
        opnd_busy = busy(iss_src0) || busy(iss_src1) || busy(iss_dst);
        sel_type  = win_type[iss_warp][iss_slot];
    end

    AST_OPND_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !opnd_busy); // R2

    AST_PEND_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> pend[$past(iss_warp)][$past(iss_dst)]); // R3

    AST_WB_WAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> pend[wb_warp][wb_reg]); // R3

    AST_SLOT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> win_valid[iss_warp][iss_slot]); // R9

    AST_WARP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> !(iss_valid && (iss_warp == $past(iss_warp)))); // R5

    AST_PORT_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> ((sel_type == 2'd0) ? (iss_port <= 2'd1) :
                       (sel_type == 2'd1) ? (iss_port == 2'd2) :
                                            (iss_port == 2'd3))); // R7

    if (ALU_OCC > 1) begin : g_alu_hold
        AST_ALU0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid && iss_port == 2'd0) |=> !(iss_valid && iss_port == 2'd0)); // R8
        AST_ALU1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid && iss_port == 2'd1) |=> !(iss_valid && iss_port == 2'd1)); // R8
    end

    if (SFU_OCC > 1) begin : g_sfu_hold
        AST_SFU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid && iss_port == 2'd2) |=> !(iss_valid && iss_port == 2'd2)); // R8
    end
endmodule

bind warp_sb_sched sbs_checker #(
    .NW      (NW),
    .WIN     (WIN),
    .NREG    (NREG),
    .ALU_OCC (ALU_OCC),
    .SFU_OCC (SFU_OCC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_valid (win_valid),
    .win_type  (win_type),
    .pend      (st_q.pend),
    .iss_valid (iss_valid),
    .iss_warp  (iss_warp),
    .iss_slot  (iss_slot),
    .iss_port  (iss_port),
    .iss_src0  (iss_src0),
    .iss_src1  (iss_src1),
    .iss_dst   (iss_dst),
    .wb_valid  (wb_valid),
    .wb_warp   (wb_warp),
    .wb_reg    (wb_reg)
);

// File: tb/sim_warp_sb_sched.sv
module sim_warp_sb_sched;
    localparam int NW = 4, WIN = 4, NREG = 16, LAT = 18, ALU_OCC = 2, SFU_OCC = 4;
    localparam int WW = $clog2(NW), SW = $clog2(WIN), RW = $clog2(NREG);
    localparam int PLEN = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [NW-1:0][WIN-1:0]         win_valid;
    logic [NW-1:0][WIN-1:0][RW-1:0] win_src0, win_src1, win_dst;
    logic [NW-1:0][WIN-1:0][1:0]    win_type;
    logic iss_valid, wb_valid;
    logic [WW-1:0] iss_warp, wb_warp;
    logic [SW-1:0] iss_slot;
    logic [1:0] iss_port;
    logic [RW-1:0] iss_src0, iss_src1, iss_dst, wb_reg;

    warp_sb_sched #(.NW(NW), .WIN(WIN), .NREG(NREG), .LAT(LAT),
                    .ALU_OCC(ALU_OCC), .SFU_OCC(SFU_OCC)) u0 (
        .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_src0(win_src0),
        .win_src1(win_src1), .win_dst(win_dst), .win_type(win_type),
        .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_slot(iss_slot),
        .iss_port(iss_port), .iss_src0(iss_src0), .iss_src1(iss_src1),
        .iss_dst(iss_dst), .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg));

    int total = 0, bad = 0;
    bit fin = 0;

    // programs and bench-side timing model
    int p_s0[NW][PLEN], p_s1[NW][PLEN], p_d[NW][PLEN], p_t[NW][PLEN];
    bit p_done[NW][PLEN];
    int p_len[NW];
    int icyc[NW][PLEN], iprt[NW][PLEN];
    int widx[NW][WIN];
    int rdy_t[NW][NREG];
    int pfree[4];
    int last_t[NW];
    int rr, cyc, ooo;
    bit ewb_v[64];
    int ewb_w[64], ewb_r[64];
    bit e_v;
    int e_w, e_j, e_p;
    bit prev_v;
    int prev_w;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int occ_of(input int p);
        if (p <= 1) return ALU_OCC;
        if (p == 2) return SFU_OCC;
        return 1;
    endfunction

    task automatic build_win();
        for (int w = 0; w < NW; w++) begin
            int j = 0;
            for (int s = 0; s < WIN; s++) begin
                win_valid[w][s] = 1'b0;
                win_src0[w][s] = '0; win_src1[w][s] = '0;
                win_dst[w][s] = '0;  win_type[w][s] = '0;
            end
            for (int k = 0; k < p_len[w]; k++) begin
                if (!p_done[w][k] && j < WIN) begin
                    win_valid[w][j] = 1'b1;
                    win_src0[w][j] = RW'(p_s0[w][k]);
                    win_src1[w][j] = RW'(p_s1[w][k]);
                    win_dst[w][j]  = RW'(p_d[w][k]);
                    win_type[w][j] = 2'(p_t[w][k]);
                    widx[w][j] = k;
                    j++;
                end
            end
        end
    endtask

    function automatic void predict();
        e_v = 0; e_w = 0; e_j = 0; e_p = 0;
        for (int o = 1; o <= NW; o++) begin
            int w = (rr + o) % NW;
            if (!e_v && (cyc - last_t[w] >= 2)) begin
                for (int j = 0; j < WIN; j++) begin
                    if (!e_v && win_valid[w][j]) begin
                        bit ok = 1;
                        int p = -1;
                        int a = win_src0[w][j], b = win_src1[w][j], d = win_dst[w][j];
                        if (rdy_t[w][a] > cyc || rdy_t[w][b] > cyc || rdy_t[w][d] > cyc) ok = 0;
                        for (int k = 0; k < j; k++) begin
                            if (win_valid[w][k] &&
                                (d == int'(win_src0[w][k]) || d == int'(win_src1[w][k]) ||
                                 d == int'(win_dst[w][k]) || a == int'(win_dst[w][k]) ||
                                 b == int'(win_dst[w][k]))) ok = 0;
                        end
                        case (int'(win_type[w][j]))
                            0: p = (pfree[0] <= cyc) ? 0 : ((pfree[1] <= cyc) ? 1 : -1);
                            1: p = (pfree[2] <= cyc) ? 2 : -1;
                            default: p = (pfree[3] <= cyc) ? 3 : -1;
                        endcase
                        if (ok && p >= 0) begin
                            e_v = 1; e_w = w; e_j = j; e_p = p;
                        end
                    end
                end
            end
        end
    endfunction

    task automatic step();
        int k;
        @(negedge clk);
        predict();
        chk(iss_valid === e_v, "R2 issue valid", int'(iss_valid), int'(e_v));
        if (e_v && iss_valid) begin
            chk(int'(iss_warp) == e_w, "R6 granted warp", int'(iss_warp), e_w);
            chk(int'(iss_slot) == e_j, "R4 granted slot", int'(iss_slot), e_j);
            chk(int'(iss_port) == e_p, "R7 target port", int'(iss_port), e_p);
            chk(iss_dst == win_dst[e_w][e_j] && iss_src0 == win_src0[e_w][e_j] &&
                iss_src1 == win_src1[e_w][e_j], "R9 issued fields",
                int'(iss_dst), int'(win_dst[e_w][e_j]));
        end
        if (iss_valid) begin
            chk(rdy_t[iss_warp][iss_src0] <= cyc && rdy_t[iss_warp][iss_src1] <= cyc &&
                rdy_t[iss_warp][iss_dst] <= cyc, "R2 operand pending at issue", 1, 0);
            chk(!(prev_v && int'(iss_warp) == prev_w), "R5 warp back-to-back",
                int'(iss_warp), prev_w);
        end
        prev_v = iss_valid;
        prev_w = int'(iss_warp);
        k = cyc % 64;
        chk(wb_valid === ewb_v[k], "R3 writeback valid", int'(wb_valid), int'(ewb_v[k]));
        if (wb_valid && ewb_v[k])
            chk(int'(wb_warp) == ewb_w[k] && int'(wb_reg) == ewb_r[k], "R3 writeback target",
                int'(wb_reg), ewb_r[k]);
        ewb_v[k] = 0;
        if (e_v) begin
            int pi = widx[e_w][e_j];
            int d = win_dst[e_w][e_j];
            p_done[e_w][pi] = 1;
            icyc[e_w][pi] = cyc;
            iprt[e_w][pi] = e_p;
            rdy_t[e_w][d] = cyc + LAT;
            pfree[e_p] = cyc + occ_of(e_p);
            last_t[e_w] = cyc;
            rr = e_w;
            if (e_j > 0) ooo++;
            ewb_v[(cyc + LAT) % 64] = 1;
            ewb_w[(cyc + LAT) % 64] = e_w;
            ewb_r[(cyc + LAT) % 64] = d;
        end
        cyc++;
        @(posedge clk);
        #1;
        build_win();
    endtask

    task automatic clear_prog();
        for (int w = 0; w < NW; w++) begin
            p_len[w] = 0;
            for (int k = 0; k < PLEN; k++) begin
                p_done[w][k] = 0; icyc[w][k] = -1; iprt[w][k] = -1;
            end
        end
    endtask

    task automatic add(input int w, input int a, input int b, input int d, input int t);
        p_s0[w][p_len[w]] = a; p_s1[w][p_len[w]] = b;
        p_d[w][p_len[w]] = d;  p_t[w][p_len[w]] = t;
        p_len[w]++;
    endtask

    function automatic bit all_done();
        for (int w = 0; w < NW; w++)
            for (int k = 0; k < p_len[w]; k++)
                if (!p_done[w][k]) return 0;
        return 1;
    endfunction

    task automatic drain();
        int guard = 0;
        while (!all_done() && guard < 5000) begin
            step();
            guard++;
        end
        repeat (LAT + 4) step();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        cyc = 0; rr = NW - 1; ooo = 0; prev_v = 0; prev_w = 0;
        for (int w = 0; w < NW; w++) begin
            last_t[w] = -100;
            for (int r = 0; r < NREG; r++) rdy_t[w][r] = 0;
        end
        for (int p = 0; p < 4; p++) pfree[p] = 0;
        for (int i = 0; i < 64; i++) ewb_v[i] = 0;
        clear_prog();
        build_win();
        repeat (4) @(posedge clk);
        #1;
        // R1: idle outputs straight after reset
        @(negedge clk);
        chk(iss_valid === 1'b0, "R1 no issue after reset", int'(iss_valid), 0);
        chk(wb_valid === 1'b0, "R1 no writeback after reset", int'(wb_valid), 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1/R6: all four warps ready, grants in order 0,1,2,3
        for (int w = 0; w < NW; w++) add(w, 1, 1, 8 + w, 2);
        build_win();
        drain();
        for (int w = 1; w < NW; w++)
            chk(icyc[w][0] == icyc[0][0] + w, "R1 first grant order", icyc[w][0], icyc[0][0] + w);
        // R3/R4: dependent pair and overtaking younger entry
        clear_prog();
        add(0, 1, 2, 5, 0); add(0, 5, 0, 6, 0); add(0, 3, 4, 7, 0);
        drain();
        chk(icyc[0][1] - icyc[0][0] == LAT, "R3 dependent spacing", icyc[0][1] - icyc[0][0], LAT);
        chk(icyc[0][2] < icyc[0][1], "R4 younger overtakes stalled", icyc[0][2], icyc[0][1]);
        // R4: write held behind older reader
        clear_prog();
        add(1, 1, 2, 10, 0); add(1, 10, 3, 11, 0); add(1, 4, 5, 3, 2);
        drain();
        chk(icyc[1][2] > icyc[1][1], "R4 write waits for older reader", icyc[1][2], icyc[1][1]);
        // R8: special-function port spacing
        clear_prog();
        add(2, 1, 2, 4, 1); add(2, 1, 2, 5, 1); add(2, 1, 2, 6, 1);
        drain();
        chk(icyc[2][1] - icyc[2][0] == SFU_OCC, "R8 sfu hold", icyc[2][1] - icyc[2][0], SFU_OCC);
        chk(icyc[2][2] - icyc[2][1] == SFU_OCC, "R8 sfu hold", icyc[2][2] - icyc[2][1], SFU_OCC);
        chk(iprt[2][0] == 2, "R7 sfu port", iprt[2][0], 2);
        // R7: ALU spill to second port
        clear_prog();
        add(0, 1, 1, 2, 0); add(1, 1, 1, 3, 0);
        drain();
        chk(iprt[0][0] + iprt[1][0] == 1, "R7 alu spill", iprt[0][0] + iprt[1][0], 1);
        chk(icyc[1][0] - icyc[0][0] == 1 || icyc[0][0] - icyc[1][0] == 1,
            "R6 other warp next cycle", icyc[1][0] - icyc[0][0], 1);
        // random traffic
        for (int ph = 0; ph < 3; ph++) begin
            int rmax = (ph == 0) ? 5 : ((ph == 1) ? 7 : NREG - 1);
            clear_prog();
            for (int w = 0; w < NW; w++)
                for (int k = 0; k < 48; k++)
                    add(w, $urandom_range(0, rmax), $urandom_range(0, rmax),
                        $urandom_range(0, rmax), $urandom_range(0, 3));
            drain();
            chk(all_done(), "R2 random program completes", int'(all_done()), 1);
        end
        chk(ooo > 0, "R4 out-of-order issues seen", ooo, 1);
        fin = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule